// File: doc/BRIEF.md
# Parallel Program and Verify Mode Controller

This block is the device-side controller that a production programmer uses to write and read back a device's on-chip nonvolatile areas over parallel ports. The programmer holds the device reset pin high and the program-store enable strobe low. Once both have been qualified for a fixed number of clocks, the controller treats an 8-bit mode code as a command. It splits a 16-bit address across two byte ports. Programming pulses arrive on a strobe pin, and verify data is returned on a byte port together with an output enable.

Five stores hang off the controller: code memory, configuration bytes, three lock bits, a key array that scrambles code verify output, and fixed identification bytes. They are modelled here as registers. Programming can only clear bits. The one exception is the lock bits, which are one-way set flags. A permit input from the security logic decides whether code and key accesses are allowed.

Verify output is not driven until the address and mode have stayed unchanged for a fixed settling time. The programmer therefore samples it only after that delay.

Top module: `nvm_pgm_ctrl`

## Requirements
- R1: The mode becomes active only after `dev_reset_i`=1 and `psen_ni`=0 have been sampled on 14 consecutive rising edges. If either is seen deasserted on any edge, the mode drops at once and the 14-edge count starts again.
- R2: `rdata_oe_o` rises exactly 48 rising edges after the first edge that samples a new {mode, address}. Any change to mode or address restarts this count. While `rdata_oe_o` is 0, `rdata_o` is 00h.
- R3: A program write happens on a rising edge that sees `prog_ni` fall, but only while the mode is active and `hv_i`=1. Write codes: 68h writes code, 69h writes configuration, 6Bh writes lock, 6Ch writes key. With `hv_i`=0 a pulse changes nothing.
- R4: Cells reset to FFh. A code, key or configuration write stores old AND data, so it can only clear bits.
- R5: Verify code 28h returns the code byte XNOR the key byte at address bits [6:0], for addresses below 2^CODE_AW.
- R6: Verify code 29h at 0030h/0031h/0060h/0061h returns 58h/40h/FBh/FFh.
- R7: Code 6Bh at 0001h, 0002h and 0003h sets lock flag 0, 1 and 2, and the write data is ignored. Verify code 2Bh at 0000h returns {5'b0, flag2, flag1, flag0}.
- R8: Unknown mode codes, program codes, out-of-range addresses, and verify while `hv_i`=1 write nothing and leave `rdata_oe_o` at 0.
- R9: With `permit_i`=0, code and key writes are ignored and code verify leaves `rdata_oe_o` at 0. Configuration and lock access are not affected.
- R10: Configuration bytes sit at 0080h–0083h. Code 69h writes them and code 29h reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low controller reset |
| dev_reset_i | input | 1 | Device reset pin, held high for the mode |
| psen_ni | input | 1 | Program-store enable strobe, held low for the mode |
| prog_ni | input | 1 | Active-low programming pulse |
| hv_i | input | 1 | Programming high voltage present |
| permit_i | input | 1 | Security permit for code and key access |
| mode_i | input | 8 | Mode code |
| addr_hi_i | input | 8 | Address bits [15:8] |
| addr_lo_i | input | 8 | Address bits [7:0] |
| wdata_i | input | 8 | Program data |
| rdata_o | output | 8 | Verify data |
| rdata_oe_o | output | 1 | Verify data drive enable |

## Verification
Each store is written and read back with chosen patterns: A5h followed by 5Ah on the same code cell, a key byte of 0Fh, and configuration and lock writes. These tell a true AND write apart from a plain overwrite, and a correct key index apart from a wrong one. The enable edge is checked at one cycle before and exactly at the 48th edge, both after mode entry and after an address change part-way through the count. This separates the correct delay from off-by-one errors. Other stimulus includes entry-line glitches, pulses with high voltage absent, unknown and program-only codes used for verify, out-of-range addresses, and permit removal. Each of these must leave a visible store or the enable untouched.

// File: rtl/nvm_pgm_pkg.sv
package nvm_pgm_pkg;
  localparam logic [7:0] MD_PGM_CODE = 8'h68;
  localparam logic [7:0] MD_PGM_CFG  = 8'h69;
  localparam logic [7:0] MD_PGM_LOCK = 8'h6B;
  localparam logic [7:0] MD_PGM_KEY  = 8'h6C;
  localparam logic [7:0] MD_VFY_CODE = 8'h28;
  localparam logic [7:0] MD_VFY_CFG  = 8'h29;
  localparam logic [7:0] MD_VFY_LOCK = 8'h2B;

  // {hit, data} for the fixed identification bytes
  function automatic logic [8:0] sig_lookup(input logic [15:0] a);
    case (a)
      16'h0030: return {1'b1, 8'h58};
      16'h0031: return {1'b1, 8'h40};
      16'h0060: return {1'b1, 8'hFB};
      16'h0061: return {1'b1, 8'hFF};
      default:  return 9'h000;
    endcase
  endfunction
endpackage

// File: rtl/nvm_entry_qual.sv
module nvm_entry_qual #(
  parameter int QUAL_CYC = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_reset_i,
  input  logic psen_ni,
  output logic active_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QUAL_C = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q;
  logic          qual_ok;

  assign qual_ok  = dev_reset_i & ~psen_ni;
  assign active_o = (cnt_q == QUAL_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!qual_ok)    cnt_q <= '0;
    else if (!active_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R1
  entry_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_ok |=> !active_o);
endmodule

// File: rtl/nvm_settle_timer.sv
module nvm_settle_timer #(
  parameter int DLY   = 48,
  parameter int KEY_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             ready_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] DLY_C = CW'(DLY);

  logic [CW-1:0]    cnt_q;
  logic [KEY_W-1:0] key_q;

  assign ready_o = (cnt_q == DLY_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      key_q <= '0;
    end else begin
      key_q <= key_i;
      if (!active_i || key_i != key_q) cnt_q <= '0;
      else if (!ready_o)               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  settle_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(key_i) |=> !ready_o);
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int CODE_AW = 8,
  parameter int KEY_AW  = 7,
  parameter int CFG_N   = 4,
  parameter int LOCK_N  = 3,
  localparam int CFG_IW = $clog2(CFG_N),
  localparam int LK_IW  = $clog2(LOCK_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_we_i,
  input  logic              key_we_i,
  input  logic              cfg_we_i,
  input  logic              lock_we_i,
  input  logic [CODE_AW-1:0] code_idx_i,
  input  logic [KEY_AW-1:0] key_idx_i,
  input  logic [CFG_IW-1:0] cfg_idx_i,
  input  logic [LK_IW-1:0]  lock_idx_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        code_rd_o,
  output logic [7:0]        cfg_rd_o,
  output logic [LOCK_N-1:0] lock_o
);
  localparam int CODE_N = 1 << CODE_AW;
  localparam int KEY_N  = 1 << KEY_AW;

  logic [7:0]        code_q [CODE_N];
  logic [7:0]        key_q  [KEY_N];
  logic [7:0]        cfg_q  [CFG_N];
  logic [LOCK_N-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CODE_N; i++) code_q[i] <= 8'hFF;
      for (int i = 0; i < KEY_N; i++)  key_q[i]  <= 8'hFF;
      for (int i = 0; i < CFG_N; i++)  cfg_q[i]  <= 8'hFF;
      lock_q <= '0;
    end else begin
      if (code_we_i) code_q[code_idx_i] <= code_q[code_idx_i] & wdata_i;
      if (key_we_i)  key_q[key_idx_i]   <= key_q[key_idx_i] & wdata_i;
      if (cfg_we_i)  cfg_q[cfg_idx_i]   <= cfg_q[cfg_idx_i] & wdata_i;
      if (lock_we_i) lock_q[lock_idx_i] <= 1'b1;
    end
  end

  assign code_rd_o = code_q[code_idx_i] ~^ key_q[key_idx_i];
  assign cfg_rd_o  = cfg_q[cfg_idx_i];
  assign lock_o    = lock_q;

  // R7
  lock_oneway_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &(~$past(lock_q) | lock_q));
endmodule

// File: rtl/nvm_pgm_ctrl.sv
module nvm_pgm_ctrl
  import nvm_pgm_pkg::*;
#(
  parameter int CODE_AW  = 8,
  parameter int KEY_AW   = 7,
  parameter int CFG_N    = 4,
  parameter int QUAL_CYC = 14,
  parameter int VFY_DLY  = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dev_reset_i,
  input  logic       psen_ni,
  input  logic       prog_ni,
  input  logic       hv_i,
  input  logic       permit_i,
  input  logic [7:0] mode_i,
  input  logic [7:0] addr_hi_i,
  input  logic [7:0] addr_lo_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rdata_oe_o
);
  localparam int LOCK_N = 3;
  localparam int CFG_IW = $clog2(CFG_N);
  localparam int LK_IW  = $clog2(LOCK_N);
  localparam logic [15:0] CFG_BASE = 16'h0080;
  localparam logic [15:0] CFG_END  = CFG_BASE + 16'(CFG_N);

  logic [15:0] addr_w;
  logic        active, ready, prog_q, pgm_fire;
  logic        code_hit, key_hit, cfg_hit, lkp_hit;
  logic        code_we, key_we, cfg_we, lock_we;
  logic [7:0]  code_rd, cfg_rd;
  logic [LOCK_N-1:0] lock_st;
  logic [8:0]  sig;
  logic        vhit;
  logic [7:0]  vdata;

  assign addr_w = {addr_hi_i, addr_lo_i};

  nvm_entry_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i, .rst_ni, .dev_reset_i, .psen_ni, .active_o(active)
  );

  nvm_settle_timer #(.DLY(VFY_DLY), .KEY_W(24)) u_timer (
    .clk_i, .rst_ni, .active_i(active), .key_i({mode_i, addr_w}), .ready_o(ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b1;
    else         prog_q <= prog_ni;
  end

  assign pgm_fire = active & hv_i & prog_q & ~prog_ni;

  assign code_hit = (addr_w >> CODE_AW) == 16'h0;
  assign key_hit  = (addr_w >> KEY_AW) == 16'h0;
  assign cfg_hit  = (addr_w >= CFG_BASE) && (addr_w < CFG_END);
  assign lkp_hit  = (addr_w >= 16'h0001) && (addr_w <= 16'h0003);

  assign code_we = pgm_fire & permit_i & code_hit & (mode_i == MD_PGM_CODE);
  assign key_we  = pgm_fire & permit_i & key_hit  & (mode_i == MD_PGM_KEY);
  assign cfg_we  = pgm_fire & cfg_hit & (mode_i == MD_PGM_CFG);
  assign lock_we = pgm_fire & lkp_hit & (mode_i == MD_PGM_LOCK);

  nvm_store #(.CODE_AW(CODE_AW), .KEY_AW(KEY_AW), .CFG_N(CFG_N), .LOCK_N(LOCK_N)) u_store (
    .clk_i, .rst_ni,
    .code_we_i(code_we), .key_we_i(key_we), .cfg_we_i(cfg_we), .lock_we_i(lock_we),
    .code_idx_i(addr_w[CODE_AW-1:0]),
    .key_idx_i(addr_w[KEY_AW-1:0]),
    .cfg_idx_i(addr_w[CFG_IW-1:0]),
    .lock_idx_i(LK_IW'(addr_w[1:0] - 2'd1)),
    .wdata_i,
    .code_rd_o(code_rd), .cfg_rd_o(cfg_rd), .lock_o(lock_st)
  );

  assign sig = sig_lookup(addr_w);

  always_comb begin
    vhit  = 1'b0;
    vdata = 8'h00;
    case (mode_i)
      MD_VFY_CODE: begin
        vhit  = code_hit & permit_i;
        vdata = code_rd;
      end
      MD_VFY_CFG: begin
        if (cfg_hit) begin
          vhit  = 1'b1;
          vdata = cfg_rd;
        end else if (sig[8]) begin
          vhit  = 1'b1;
          vdata = sig[7:0];
        end
      end
      MD_VFY_LOCK: begin
        vhit  = (addr_w == 16'h0000);
        vdata = {{(8-LOCK_N){1'b0}}, lock_st};
      end
      default: ;
    endcase
  end

  assign rdata_oe_o = active & ready & vhit & ~hv_i;
  assign rdata_o    = rdata_oe_o ? vdata : 8'h00;

  // R8
  verify_codes_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!hv_i && (mode_i == MD_VFY_CODE || mode_i == MD_VFY_CFG ||
                              mode_i == MD_VFY_LOCK)));

  // R9
  permit_code_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!permit_i && mode_i == MD_VFY_CODE) |-> !rdata_oe_o);
endmodule

// File: tb/nvm_pgm_ctrl_tb_top.sv
module nvm_pgm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dev_reset = 1'b1;
  logic       psen_n = 1'b0;
  logic       prog_n = 1'b1;
  logic       hv = 1'b0;
  logic       permit = 1'b1;
  logic [7:0] mode = 8'h29;
  logic [15:0] addr = 16'h0030;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  nvm_pgm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dev_reset_i(dev_reset), .psen_ni(psen_n),
    .prog_ni(prog_n), .hv_i(hv), .permit_i(permit), .mode_i(mode),
    .addr_hi_i(addr[15:8]), .addr_lo_i(addr[7:0]), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  // {is_pgm, hv, mode, addr, data, exp_oe, exp_data, req}
  localparam int NV = 31;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0,1'b0,8'h28,16'h0005,8'h00,1'b1,8'hFF,4'd4},  // R4 erased
    {1'b1,1'b1,8'h68,16'h0005,8'hA5,1'b0,8'h00,4'd3},
    {1'b0,1'b0,8'h28,16'h0005,8'h00,1'b1,8'hA5,4'd3},  // R3
    {1'b1,1'b1,8'h68,16'h0005,8'h5A,1'b0,8'h00,4'd4},
    {1'b0,1'b0,8'h28,16'h0005,8'h00,1'b1,8'h00,4'd4},  // R4 AND
    {1'b1,1'b1,8'h6C,16'h0005,8'h0F,1'b0,8'h00,4'd5},
    {1'b0,1'b0,8'h28,16'h0005,8'h00,1'b1,8'hF0,4'd5},  // R5
    {1'b0,1'b0,8'h28,16'h0085,8'h00,1'b1,8'h0F,4'd5},  // R5 key index wraps
    {1'b1,1'b0,8'h68,16'h0010,8'h00,1'b0,8'h00,4'd3},  // no hv
    {1'b0,1'b0,8'h28,16'h0010,8'h00,1'b1,8'hFF,4'd3},
    {1'b0,1'b0,8'h29,16'h0030,8'h00,1'b1,8'h58,4'd6},  // R6
    {1'b0,1'b0,8'h29,16'h0031,8'h00,1'b1,8'h40,4'd6},
    {1'b0,1'b0,8'h29,16'h0060,8'h00,1'b1,8'hFB,4'd6},
    {1'b0,1'b0,8'h29,16'h0061,8'h00,1'b1,8'hFF,4'd6},
    {1'b1,1'b1,8'h69,16'h0082,8'h3C,1'b0,8'h00,4'd10},
    {1'b0,1'b0,8'h29,16'h0082,8'h00,1'b1,8'h3C,4'd10}, // R10
    {1'b0,1'b0,8'h29,16'h0080,8'h00,1'b1,8'hFF,4'd10},
    {1'b0,1'b0,8'h2B,16'h0000,8'h00,1'b1,8'h00,4'd7},  // R7
    {1'b1,1'b1,8'h6B,16'h0002,8'h55,1'b0,8'h00,4'd7},
    {1'b0,1'b0,8'h2B,16'h0000,8'h00,1'b1,8'h02,4'd7},
    {1'b1,1'b1,8'h6B,16'h0001,8'h00,1'b0,8'h00,4'd7},
    {1'b0,1'b0,8'h2B,16'h0000,8'h00,1'b1,8'h03,4'd7},
    {1'b0,1'b0,8'h2B,16'h0001,8'h00,1'b0,8'h00,4'd8},  // R8
    {1'b0,1'b0,8'h55,16'h0030,8'h00,1'b0,8'h00,4'd8},
    {1'b0,1'b0,8'h68,16'h0005,8'h00,1'b0,8'h00,4'd8},
    {1'b0,1'b0,8'h28,16'h0100,8'h00,1'b0,8'h00,4'd8},
    {1'b0,1'b1,8'h29,16'h0030,8'h00,1'b0,8'h00,4'd8},
    {1'b1,1'b1,8'h77,16'h0005,8'h00,1'b0,8'h00,4'd8},
    {1'b0,1'b0,8'h28,16'h0005,8'h00,1'b1,8'hF0,4'd8},
    {1'b1,1'b1,8'h69,16'h0090,8'h00,1'b0,8'h00,4'd8},
    {1'b0,1'b0,8'h29,16'h0080,8'h00,1'b1,8'hFF,4'd8}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input int req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic do_pgm(input logic h, input logic [7:0] m, input logic [15:0] a,
                        input logic [7:0] d);
    hv = h; mode = m; addr = a; wdata = d;
    tick(2);
    prog_n = 1'b0;
    tick(1);
    prog_n = 1'b1;
    tick(1);
    hv = 1'b0;
  endtask

  task automatic do_vfy(input logic h, input logic [7:0] m, input logic [15:0] a,
                        input logic eoe, input logic [7:0] ed, input int req);
    hv = h; mode = 8'h00;
    tick(1);
    mode = m; addr = a;
    tick(48);
    chk(rdata_oe == 1'b0 && rdata == 8'h00, 2, {rdata_oe, rdata}, 0);  // R2 early
    tick(1);
    chk(rdata_oe == eoe, req, rdata_oe, eoe);
    chk(rdata == (eoe ? ed : 8'h00), req, rdata, eoe ? ed : 8'h00);
    hv = 1'b0;
  endtask

  initial begin
    tick(3);
    // R2 reset state
    chk(rdata_oe == 1'b0 && rdata == 8'h00, 2, {rdata_oe, rdata}, 0);
    rst_ni = 1'b1;
    // R1 entry: 14 edges then 48 settle edges
    tick(61);
    chk(rdata_oe == 1'b0, 1, rdata_oe, 0);
    tick(1);
    chk(rdata_oe == 1'b1 && rdata == 8'h58, 1, {rdata_oe, rdata}, 9'h158);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46])
        do_pgm(VEC[i][45], VEC[i][44:37], VEC[i][36:21], VEC[i][20:13]);
      else
        do_vfy(VEC[i][45], VEC[i][44:37], VEC[i][36:21], VEC[i][12], VEC[i][11:4],
               int'(VEC[i][3:0]));
    end

    // R2 address change mid-count restarts the delay
    mode = 8'h00; tick(1);
    mode = 8'h29; addr = 16'h0030;
    tick(30);
    addr = 16'h0031;
    tick(48);
    chk(rdata_oe == 1'b0, 2, rdata_oe, 0);
    tick(1);
    chk(rdata_oe == 1'b1 && rdata == 8'h40, 2, {rdata_oe, rdata}, 9'h140);

    // R1 strobe glitch drops the mode, re-entry takes 14+48 edges
    psen_n = 1'b1;
    tick(1);
    chk(rdata_oe == 1'b0, 1, rdata_oe, 0);
    psen_n = 1'b0;
    tick(61);
    chk(rdata_oe == 1'b0, 1, rdata_oe, 0);
    tick(1);
    chk(rdata_oe == 1'b1, 1, rdata_oe, 1);

    // R1 device reset released
    dev_reset = 1'b0;
    tick(1);
    chk(rdata_oe == 1'b0, 1, rdata_oe, 0);
    dev_reset = 1'b1;
    tick(62);
    chk(rdata_oe == 1'b1 && rdata == 8'h40, 1, {rdata_oe, rdata}, 9'h140);

    // R9 permit withdrawn
    permit = 1'b0;
    do_vfy(1'b0, 8'h28, 16'h0005, 1'b0, 8'h00, 9);
    do_pgm(1'b1, 8'h68, 16'h0020, 8'h00);
    do_pgm(1'b1, 8'h6C, 16'h0020, 8'h00);
    do_pgm(1'b1, 8'h69, 16'h0083, 8'h11);
    do_vfy(1'b0, 8'h29, 16'h0083, 1'b1, 8'h11, 9);
    permit = 1'b1;
    do_vfy(1'b0, 8'h28, 16'h0020, 1'b1, 8'hFF, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule